// File: doc/BRIEF.md
# Grid Element Configuration Command Handler

This block sits in every element of a square grid of processing elements and handles the configuration traffic that loads programs and data before a compute run. Command words enter from the north and west neighbours. Each word names a target element by its X/Y coordinates. An element that is not the target copies the word, unchanged, onto both its south and east outputs. Words therefore spread from the north-west corner across the grid as a diagonal wave, one element per clock.

The target element writes or reads its own storage. This storage is four 32-bit operand banks, one 40-bit control bank and the program counter. A read sends back a reply word that carries the data, and the reply travels onward through the south and east outputs like any other word.

A side port takes 32-bit halves on two consecutive cycles and joins them into a full command word. This port serves the corner element that talks to the outside of the chip. While the global compute enable is high, the handler ignores every input.

Top module: `cfg_mesh_node`

## Requirements
- R1: While reset is low, and in the first cycle after it, both output valids are low. Every storage location and the program counter read back as zero after reset.
- R2: A command word is 56 bits wide. Its fields are opcode [1:0], X [3:2], Y [5:4], bank [8:6], offset [15:9] and value [55:16]. A valid word whose X/Y differ from the element's own is copied unchanged to both the south and east outputs one clock after it is accepted.
- R3: Opcodes are 00 idle, 01 read, 10 write and 11 reply. Banks 000 to 011 are the operand banks. A write to an operand bank stores value[31:0]. A read of an operand bank produces, one clock later, a reply word on both outputs. The reply has opcode 11, the element's own X/Y, the bank and offset of the request, and the stored data zero-extended to 40 bits.
- R4: Bank 100 is the control bank. A write stores all 40 value bits, and a read returns all 40.
- R5: Bank 111 is the program counter. A write loads value[6:0], whatever the offset. A read returns the counter zero-extended.
- R6: Banks 101 and 110 are unused. A write to them changes no storage. A read of them still produces a reply whose value field is zero.
- R7: A write or an idle word addressed to this element produces no output word.
- R8: A reply word (opcode 11) is always forwarded unchanged, even when its coordinates match this element.
- R9: When north and west both carry a valid word in the same cycle, the north word is handled that cycle. The west word is handled in the next cycle, provided north is idle then.
- R10: While the compute enable input is high, every input is ignored. No output appears, no storage changes and no west word is kept for later.
- R11: On the side port, the first valid half gives word bits [31:0] and the next valid half gives bits [55:32] from its low 24 bits. The joined word is handled two clocks after the second half is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| compute_en | input | 1 | High selects compute mode; configuration handling is idle |
| n_vld | input | 1 | North command valid |
| n_word | input | 56 | North command word |
| w_vld | input | 1 | West command valid |
| w_word | input | 56 | West command word |
| side_vld | input | 1 | Side-port half valid |
| side_half | input | 32 | Side-port half word |
| s_vld | output | 1 | South output valid |
| s_word | output | 56 | South output word |
| e_vld | output | 1 | East output valid |
| e_word | output | 56 | East output word |

## Verification
The bench builds the element at X=1, Y=2 with 2-bit coordinates, 7-bit offsets and four operand banks. Because both coordinates are non-zero, the bench can send words that miss on X alone and words that miss on Y alone. With offsets of 7 bits, the top location 127 of an operand bank is within reach. The 40-bit value width lets the bench show the difference between the control bank, which keeps all 40 bits, and the operand banks, which drop the top 8 bits.

// File: rtl/cfg_mesh_pkg.sv
// Shared definitions for the grid configuration handler.
// Assumes the opcode field is two bits wide in every element of the grid.
package cfg_mesh_pkg;

    // Command opcodes; neighbours decode these, so the codes are fixed.
    typedef enum logic [1:0] {
        OP_IDLE   = 2'b00,
        OP_READ   = 2'b01,
        OP_WRITE  = 2'b10,
        OP_REPLY  = 2'b11
    } cfg_op_t;

    localparam int OP_W = 2;

    // Bank select codes for the non-operand targets.
    localparam int BANK_CTRL_CODE = 4;
    localparam int BANK_PC_CODE   = 7;

endpackage

// File: rtl/cfg_half_joiner.sv
// Joins two consecutive side-port halves into one command word.
// The first valid half supplies the low HALF_W bits and the second half
// supplies the rest from its low bits. A joined word stays pending until
// the input selector takes it. Assumes WORD_W - HALF_W <= HALF_W.
module cfg_half_joiner #(
    parameter int HALF_W = 32,
    parameter int WORD_W = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_en,
    input  logic              half_vld,
    input  logic [HALF_W-1:0] half_data,
    input  logic              take,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);

    localparam int HI_W = WORD_W - HALF_W;

    logic              phase_hi;
    logic [HALF_W-1:0] lo_q;
    logic              pend_q;
    logic [WORD_W-1:0] word_q;

    // Track which half is expected next and latch the joined word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_hi <= 1'b0;
            lo_q     <= '0;
            pend_q   <= 1'b0;
            word_q   <= '0;
        end else begin
            if (take) begin
                pend_q <= 1'b0;
            end
            if (accept_en && half_vld) begin
                if (!phase_hi) begin
                    lo_q     <= half_data;
                    phase_hi <= 1'b1;
                end else begin
                    word_q   <= {half_data[HI_W-1:0], lo_q};
                    pend_q   <= 1'b1;
                    phase_hi <= 1'b0;
                end
            end
        end
    end

    assign word_vld = pend_q;
    assign word     = word_q;

endmodule

// File: rtl/cfg_in_select.sv
// Chooses one command word per cycle from north, a one-entry west hold,
// west and the side port, in that order of priority. A west word that
// loses to north is kept in the hold and offered in the next cycle.
// Assumes upstream spacing keeps at most one west word waiting.
module cfg_in_select #(
    parameter int WORD_W = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              n_vld,
    input  logic [WORD_W-1:0] n_word,
    input  logic              w_vld,
    input  logic [WORD_W-1:0] w_word,
    input  logic              x_vld,
    input  logic [WORD_W-1:0] x_word,
    output logic              sel_vld,
    output logic [WORD_W-1:0] sel_word,
    output logic              x_take
);

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_NORTH,
        SRC_HOLD,
        SRC_WEST,
        SRC_SIDE
    } src_t;

    src_t              src;
    logic              hold_vld;
    logic [WORD_W-1:0] hold_word;

    // Pick the source for this cycle by fixed priority.
    always_comb begin
        if (!enable)        src = SRC_NONE;
        else if (n_vld)     src = SRC_NORTH;
        else if (hold_vld)  src = SRC_HOLD;
        else if (w_vld)     src = SRC_WEST;
        else if (x_vld)     src = SRC_SIDE;
        else                src = SRC_NONE;
    end

    // Route the chosen source to the output.
    always_comb begin
        sel_vld  = (src != SRC_NONE);
        unique case (src)
            SRC_NORTH: sel_word = n_word;
            SRC_HOLD:  sel_word = hold_word;
            SRC_WEST:  sel_word = w_word;
            SRC_SIDE:  sel_word = x_word;
            default:   sel_word = '0;
        endcase
    end

    assign x_take = (src == SRC_SIDE);

    // Keep a west word that lost arbitration; release the hold once used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_word <= '0;
        end else if (enable) begin
            if (w_vld && (src != SRC_WEST)) begin
                hold_vld  <= 1'b1;
                hold_word <= w_word;
            end else if (src == SRC_HOLD) begin
                hold_vld  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cfg_store.sv
// Local storage of one element: NUM_OPND operand banks, one wide control
// bank and the program counter, all cleared by reset. Writes land on the
// clock edge; the read port is combinational on bank and offset. Unused
// bank codes take no write and read as zero.
module cfg_store #(
    parameter int NUM_OPND  = 4,
    parameter int OPND_W    = 32,
    parameter int VAL_W     = 40,
    parameter int OFFS_W    = 7,
    parameter int SEL_W     = 3,
    parameter int CTRL_CODE = 4,
    parameter int PC_CODE   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  bank,
    input  logic [OFFS_W-1:0] offs,
    input  logic [VAL_W-1:0]  wdata,
    output logic [VAL_W-1:0]  rdata
);

    localparam int DEPTH = 1 << OFFS_W;

    logic [OPND_W-1:0] opnd_rd [NUM_OPND];
    logic [VAL_W-1:0]  ctrl_mem [DEPTH];
    logic [OFFS_W-1:0] pc_q;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        logic [OPND_W-1:0] mem [DEPTH];

        // Operand bank g: clear on reset, take the low value bits on write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en && (bank == SEL_W'(g))) begin
                mem[offs] <= wdata[OPND_W-1:0];
            end
        end

        assign opnd_rd[g] = mem[offs];
    end

    // Control bank: full-width words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctrl_mem[i] <= '0;
        end else if (wr_en && (bank == SEL_W'(CTRL_CODE))) begin
            ctrl_mem[offs] <= wdata;
        end
    end

    // Program counter: loaded from the low value bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (wr_en && (bank == SEL_W'(PC_CODE))) begin
            pc_q <= wdata[OFFS_W-1:0];
        end
    end

    // Read mux over all targets; unmatched codes give zero.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_OPND; b++) begin
            if (bank == SEL_W'(b)) rdata = VAL_W'(opnd_rd[b]);
        end
        if (bank == SEL_W'(CTRL_CODE)) rdata = ctrl_mem[offs];
        if (bank == SEL_W'(PC_CODE))   rdata = VAL_W'(pc_q);
    end

endmodule

// File: rtl/cfg_mesh_node.sv
// Configuration-mode command handler of one grid element at (X_POS, Y_POS).
// Each cycle one accepted word is either forwarded unchanged to south and
// east, or acted on locally (write, read with reply, idle). Outputs are
// registered, so every word advances one element per clock. Assumes the
// compute enable is held stable while configuration traffic is in flight.
module cfg_mesh_node
    import cfg_mesh_pkg::*;
#(
    parameter int X_POS    = 1,
    parameter int Y_POS    = 2,
    parameter int COORD_W  = 2,
    parameter int SEL_W    = 3,
    parameter int OFFS_W   = 7,
    parameter int VAL_W    = 40,
    parameter int OPND_W   = 32,
    parameter int NUM_OPND = 4,
    parameter int HALF_W   = 32,
    parameter int WORD_W   = OP_W + 2*COORD_W + SEL_W + OFFS_W + VAL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              compute_en,
    input  logic              n_vld,
    input  logic [WORD_W-1:0] n_word,
    input  logic              w_vld,
    input  logic [WORD_W-1:0] w_word,
    input  logic              side_vld,
    input  logic [HALF_W-1:0] side_half,
    output logic              s_vld,
    output logic [WORD_W-1:0] s_word,
    output logic              e_vld,
    output logic [WORD_W-1:0] e_word
);

    localparam int X_LO    = OP_W;
    localparam int Y_LO    = X_LO + COORD_W;
    localparam int BANK_LO = Y_LO + COORD_W;
    localparam int OFFS_LO = BANK_LO + SEL_W;
    localparam int VAL_LO  = OFFS_LO + OFFS_W;

    logic              cfg_active;
    logic              side_wvld;
    logic [WORD_W-1:0] side_word;
    logic              side_take;
    logic              sel_vld;
    logic [WORD_W-1:0] sel_word;

    cfg_op_t           f_op;
    logic [COORD_W-1:0] f_x, f_y;
    logic [SEL_W-1:0]  f_bank;
    logic [OFFS_W-1:0] f_offs;
    logic [VAL_W-1:0]  f_val;
    logic              hit;
    logic              do_fwd, do_write, do_read;
    logic [VAL_W-1:0]  rd_data;
    logic [WORD_W-1:0] reply_word;
    logic              out_vld_q;
    logic [WORD_W-1:0] out_word_q;

    assign cfg_active = !compute_en;

    cfg_half_joiner #(
        .HALF_W (HALF_W),
        .WORD_W (WORD_W)
    ) i_joiner (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_en (cfg_active),
        .half_vld  (side_vld),
        .half_data (side_half),
        .take      (side_take),
        .word_vld  (side_wvld),
        .word      (side_word)
    );

    cfg_in_select #(
        .WORD_W (WORD_W)
    ) i_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (cfg_active),
        .n_vld    (n_vld),
        .n_word   (n_word),
        .w_vld    (w_vld),
        .w_word   (w_word),
        .x_vld    (side_wvld),
        .x_word   (side_word),
        .sel_vld  (sel_vld),
        .sel_word (sel_word),
        .x_take   (side_take)
    );

    // Split the selected word into its fields.
    always_comb begin
        f_op   = cfg_op_t'(sel_word[OP_W-1:0]);
        f_x    = sel_word[X_LO +: COORD_W];
        f_y    = sel_word[Y_LO +: COORD_W];
        f_bank = sel_word[BANK_LO +: SEL_W];
        f_offs = sel_word[OFFS_LO +: OFFS_W];
        f_val  = sel_word[VAL_LO +: VAL_W];
    end

    // Decide between forwarding and a local action.
    always_comb begin
        hit      = (f_x == COORD_W'(X_POS)) && (f_y == COORD_W'(Y_POS));
        do_fwd   = sel_vld && (!hit || (f_op == OP_REPLY));
        do_write = sel_vld && hit && (f_op == OP_WRITE);
        do_read  = sel_vld && hit && (f_op == OP_READ);
    end

    cfg_store #(
        .NUM_OPND  (NUM_OPND),
        .OPND_W    (OPND_W),
        .VAL_W     (VAL_W),
        .OFFS_W    (OFFS_W),
        .SEL_W     (SEL_W),
        .CTRL_CODE (BANK_CTRL_CODE),
        .PC_CODE   (BANK_PC_CODE)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (do_write),
        .bank  (f_bank),
        .offs  (f_offs),
        .wdata (f_val),
        .rdata (rd_data)
    );

    // Build the reply for a local read: own coordinates, same location.
    assign reply_word = {rd_data, f_offs, f_bank,
                         COORD_W'(Y_POS), COORD_W'(X_POS), OP_REPLY};

    // Output register shared by the south and east links.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_q  <= 1'b0;
            out_word_q <= '0;
        end else begin
            out_vld_q <= do_fwd || do_read;
            if (do_fwd) begin
                out_word_q <= sel_word;
            end else if (do_read) begin
                out_word_q <= reply_word;
            end
        end
    end

    assign s_vld  = out_vld_q;
    assign s_word = out_word_q;
    assign e_vld  = out_vld_q;
    assign e_word = out_word_q;

endmodule

// File: rtl/cfg_mesh_node_chk.sv
// Port-level checker for the grid configuration handler, bound to every
// instance of cfg_mesh_node. Assumes the default field layout.
module cfg_mesh_node_chk #(
    parameter int X_POS   = 1,
    parameter int Y_POS   = 2,
    parameter int COORD_W = 2,
    parameter int WORD_W  = 56
) (
    input logic              clk,
    input logic              rst_n,
    input logic              compute_en,
    input logic              n_vld,
    input logic [WORD_W-1:0] n_word,
    input logic              w_vld,
    input logic [WORD_W-1:0] w_word,
    input logic              s_vld,
    input logic [WORD_W-1:0] s_word
);

    localparam int X_LO = 2;
    localparam int Y_LO = X_LO + COORD_W;

    logic n_hit, w_hit;
    logic [1:0] n_op;

    // Coordinate match and opcode of the incoming north and west words.
    assign n_hit = (n_word[X_LO +: COORD_W] == COORD_W'(X_POS)) &&
                   (n_word[Y_LO +: COORD_W] == COORD_W'(Y_POS));
    assign w_hit = (w_word[X_LO +: COORD_W] == COORD_W'(X_POS)) &&
                   (w_word[Y_LO +: COORD_W] == COORD_W'(Y_POS));
    assign n_op  = n_word[1:0];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !s_vld); // R1

    AST_MISS_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (!compute_en && n_vld && !n_hit) |=> (s_vld && s_word == $past(n_word))); // R2

    AST_READ_REPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        (!compute_en && n_vld && n_hit && n_op == 2'b01) |=> (s_vld && s_word[1:0] == 2'b11)); // R3

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!compute_en && n_vld && n_hit && n_op == 2'b10) |=> !s_vld); // R7

    AST_REPLY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!compute_en && n_vld && n_op == 2'b11) |=> (s_vld && s_word == $past(n_word))); // R8

    AST_WEST_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (!compute_en && n_vld && w_vld && !w_hit) ##1 (!compute_en && !n_vld)
        |=> (s_vld && s_word == $past(w_word, 2))); // R9

    AST_COMPUTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        compute_en |=> !s_vld); // R10

endmodule

bind cfg_mesh_node cfg_mesh_node_chk #(
    .X_POS   (X_POS),
    .Y_POS   (Y_POS),
    .COORD_W (COORD_W),
    .WORD_W  (WORD_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .compute_en (compute_en),
    .n_vld      (n_vld),
    .n_word     (n_word),
    .w_vld      (w_vld),
    .w_word     (w_word),
    .s_vld      (s_vld),
    .s_word     (s_word)
);

// File: tb/test_cfg_mesh_node.sv
module test_cfg_mesh_node;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 56;
    localparam int ENT_W      = 2*WORD_W + 1;
    localparam int NVEC       = 15;

    // Word layout: value[55:16] offset[15:9] bank[8:6] Y[5:4] X[3:2] op[1:0]
    function automatic logic [WORD_W-1:0] mk(input logic [1:0] op,
        input logic [1:0] x, input logic [1:0] y, input logic [2:0] b,
        input logic [6:0] o, input logic [39:0] v);
        return {v, o, b, y, x, op};
    endfunction

    // Entry = {input word, output expected, expected word}
    localparam logic [ENT_W-1:0] VEC [NVEC] = '{
        {mk(2'b10,1,2,0,5,40'hAB_1234_5678), 1'b0, 56'h0},                              // R7 write silent
        {mk(2'b01,1,2,0,5,0), 1'b1, mk(2'b11,1,2,0,5,40'h00_1234_5678)},                // R3 low 32 kept
        {mk(2'b10,0,2,1,3,40'h11), 1'b1, mk(2'b10,0,2,1,3,40'h11)},                     // R2 X miss
        {mk(2'b10,1,2,3,127,40'h00_DEAD_BEEF), 1'b0, 56'h0},                            // R3 top offset
        {mk(2'b01,1,2,3,127,0), 1'b1, mk(2'b11,1,2,3,127,40'h00_DEAD_BEEF)},            // R3
        {mk(2'b10,1,2,4,0,40'hC3_0000_0001), 1'b0, 56'h0},                              // R4
        {mk(2'b01,1,2,4,0,0), 1'b1, mk(2'b11,1,2,4,0,40'hC3_0000_0001)},                // R4 40 bits
        {mk(2'b10,1,2,7,33,40'h00_0000_00FF), 1'b0, 56'h0},                             // R5
        {mk(2'b01,1,2,7,9,0), 1'b1, mk(2'b11,1,2,7,9,40'h7F)},                          // R5
        {mk(2'b10,1,2,5,5,40'hFF_FFFF_FFFF), 1'b0, 56'h0},                              // R6 ignored
        {mk(2'b01,1,2,6,5,0), 1'b1, mk(2'b11,1,2,6,5,40'h0)},                           // R6 zero reply
        {mk(2'b01,1,2,0,5,0), 1'b1, mk(2'b11,1,2,0,5,40'h00_1234_5678)},                // R6 bank 0 untouched
        {mk(2'b00,1,2,0,0,40'h5), 1'b0, 56'h0},                                         // R7 idle silent
        {mk(2'b11,1,2,2,4,40'h5), 1'b1, mk(2'b11,1,2,2,4,40'h5)},                       // R8 reply passes
        {mk(2'b01,1,3,0,5,0), 1'b1, mk(2'b01,1,3,0,5,0)}                                // R2 Y miss
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              compute_en;
    logic              n_vld, w_vld, side_vld;
    logic [WORD_W-1:0] n_word, w_word;
    logic [31:0]       side_half;
    logic              s_vld, e_vld;
    logic [WORD_W-1:0] s_word, e_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_mesh_node #(.X_POS(1), .Y_POS(2)) i_cfg_mesh_node (
        .clk(clk), .rst_n(rst_n), .compute_en(compute_en),
        .n_vld(n_vld), .n_word(n_word), .w_vld(w_vld), .w_word(w_word),
        .side_vld(side_vld), .side_half(side_half),
        .s_vld(s_vld), .s_word(s_word), .e_vld(e_vld), .e_word(e_word)
    );

    task automatic chk(input string tag, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Check both links against one expectation.
    task automatic chk_out(input string tag, input logic ev,
                           input logic [WORD_W-1:0] ew);
        chk({tag, " south valid"}, WORD_W'(s_vld), WORD_W'(ev));
        chk({tag, " east valid"},  WORD_W'(e_vld), WORD_W'(ev));
        if (ev) begin
            chk({tag, " south word"}, s_word, ew);
            chk({tag, " east word"},  e_word, ew);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [ENT_W-1:0] ent;
        rst_n = 1'b0; compute_en = 1'b0;
        n_vld = 1'b0; w_vld = 1'b0; side_vld = 1'b0;
        n_word = '0; w_word = '0; side_half = '0;
        repeat (3) @(negedge clk);
        chk_out("R1 reset state", 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: storage clear after reset
        n_vld = 1'b1; n_word = mk(2'b01,1,2,2,77,0);
        @(negedge clk);
        chk_out("R1 cleared bank", 1'b1, mk(2'b11,1,2,2,77,0));
        n_vld = 1'b0;

        // Table walk over the north input
        for (int i = 0; i < NVEC; i++) begin
            ent    = VEC[i];
            n_vld  = 1'b1;
            n_word = ent[ENT_W-1 -: WORD_W];
            @(negedge clk);
            chk_out($sformatf("vector %0d", i), ent[WORD_W], ent[WORD_W-1:0]);
        end
        n_vld = 1'b0;
        @(negedge clk);

        // R9: north and west together
        n_vld = 1'b1; n_word = mk(2'b10,0,0,1,1,40'hA);
        w_vld = 1'b1; w_word = mk(2'b10,3,3,2,2,40'hB);
        @(negedge clk);
        chk_out("R9 north first", 1'b1, mk(2'b10,0,0,1,1,40'hA));
        n_vld = 1'b0; w_vld = 1'b0;
        @(negedge clk);
        chk_out("R9 west next", 1'b1, mk(2'b10,3,3,2,2,40'hB));
        @(negedge clk);
        chk_out("R9 then idle", 1'b0, '0);

        // R10: compute mode ignores everything
        compute_en = 1'b1;
        n_vld = 1'b1; n_word = mk(2'b10,1,2,1,1,40'h77);
        w_vld = 1'b1; w_word = mk(2'b10,3,3,0,0,40'h1);
        @(negedge clk);
        chk_out("R10 no output", 1'b0, '0);
        compute_en = 1'b0; w_vld = 1'b0;
        n_word = mk(2'b01,1,2,1,1,0);
        @(negedge clk);
        chk_out("R10 no write", 1'b1, mk(2'b11,1,2,1,1,40'h0));
        n_vld = 1'b0;
        @(negedge clk);
        chk_out("R10 west not kept", 1'b0, '0);

        // R11: side port halves, low first
        begin
            logic [WORD_W-1:0] sw;
            sw = mk(2'b01,1,2,3,127,0);
            side_vld = 1'b1; side_half = sw[31:0];
            @(negedge clk);
            side_half = {8'h00, sw[55:32]};
            @(negedge clk);
            side_vld = 1'b0; side_half = '0;
            chk_out("R11 not before join", 1'b0, '0);
            @(negedge clk);
            chk_out("R11 joined read", 1'b1, mk(2'b11,1,2,3,127,40'h00_DEAD_BEEF));
            @(negedge clk);
            chk_out("R11 single use", 1'b0, '0);
        end

        // R1: reset mid-run blocks a word and clears storage
        rst_n = 1'b0;
        n_vld = 1'b1; n_word = mk(2'b10,0,0,0,0,40'h9);
        @(negedge clk);
        chk_out("R1 reset blocks", 1'b0, '0);
        rst_n = 1'b1;
        n_word = mk(2'b01,1,2,4,0,0);
        @(negedge clk);
        chk_out("R1 reset clears", 1'b1, mk(2'b11,1,2,4,0,40'h0));
        n_vld = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule